// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the lowest layer of an I2C master. A command sequencer above it issues one command at a time: a START, a STOP, or a nine-bit shift. A nine-bit shift is eight data bits, most significant first, followed by one acknowledge bit. The engine turns each command into open-drain enables for SCL and SDA. Timing comes from a quarter-period count that arrives with each command. Every bit period, and every START or STOP sequence, is four quarters long. Each quarter lasts that many system clock cycles.

Two options give faster SDA edges on a bus that is otherwise pulled up only by a resistor:

- **Active high drive.** The master can drive SDA high in fixed windows instead of only releasing it.
- **Early release.** When a 0 bit is followed by a 1 bit, the master can release the low SDA as soon as SCL falls.

Early release is safe because SDA rises slowly through the resistor, so some hold time remains after SCL falls.

A START issued while the bus is already open becomes a repeated-start sequence. The engine samples SDA during each bit and returns the nine sampled bits. It does not act on the acknowledge bit. Driving SDA high can cause an acknowledge to be missed, and this is accepted.

Top module: `i2c_bit_engine`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 1, `bus_open` is 0, and both SCL and SDA are released (`scl_oe` = 0, `sda_oe` = 0).
- R2: `cmd_kind` is decoded as follows: 1 = START, 2 = STOP, 3 = nine-bit shift, 0 = no operation. A strobe is accepted only when `ready` is 1 and `cmd_kind` is not 0. `ready` goes low on the cycle after acceptance. A strobe while `ready` is low, or a strobe with kind 0, is ignored and changes neither the timing nor the bus state.
- R3: Each quarter lasts `cmd_dly` clock cycles, and `cmd_dly` must be greater than 2. `ready` returns high exactly 4×`cmd_dly` cycles after a START or STOP is accepted, and exactly 36×`cmd_dly` cycles after a shift is accepted.
- R4: A START on a closed bus works as follows:
  - SCL stays released in all four quarters.
  - SDA is released in quarters 0–1 and driven low in quarters 2–3.
  - When the START completes, `bus_open` is 1, SCL is held low and SDA is held low.
- R5: A START on an open bus is a repeated start. SCL is low in quarter 0 and released in quarters 1–3. SDA is not low in quarters 0–1 and is driven low in quarters 2–3. `bus_open` stays 1.
- R6: A STOP drives SDA low in quarters 0–2. SCL is low in quarter 0 and released in quarters 1–3. SDA is not low in quarter 3. On completion `bus_open` is 0 and both lines are released.
- R7: A shift sends `tx_data[8]` first and `tx_data[0]` last. Within each bit, SCL is pulled low (`scl_oe` = 1) in quarters 0–1 and released in quarters 2–3. In quarters 2–3, SDA is driven low for a 0 bit and released for a 1 bit.
- R8: The SDA input is sampled at the end of quarter 2 of every bit. After a shift, `rx_data[8]` holds the first sampled bit and `rx_data[0]` holds the last.
- R9: With `active_sda_en` = 1, SDA is driven high (`sda_oe` = 1, `sda_o` = 1) in three windows:
  - quarter 1 of every 1 bit;
  - quarter 0 of a repeated start;
  - quarter 3 of a STOP.
  With `active_sda_en` = 0, those windows release SDA and SDA is never driven high.
- R10: In quarter 0 of a bit, SDA keeps the previous level (low after a 0, released after a 1). The one exception is when `early_rel_en` = 1, the previous level is low and the new bit is 1: SDA is then released in quarter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_sda_en | input | 1 | Enables driving SDA high in the set windows |
| early_rel_en | input | 1 | Enables early release of a low SDA before a 1 bit |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 2 | Command type: 0 none, 1 START, 2 STOP, 3 shift |
| cmd_dly | input | 8 | Quarter-period length in clock cycles (greater than 2) |
| tx_data | input | 9 | Shift data; bit 8 is sent first, bit 0 is the acknowledge slot |
| sda_i | input | 1 | SDA pad input |
| ready | output | 1 | Engine idle and able to accept a command |
| bus_open | output | 1 | High between a completed START and a completed STOP |
| rx_data | output | 9 | Bits sampled during the last shift, first bit in bit 8 |
| scl_oe | output | 1 | SCL output enable; when 1, SCL is pulled low |
| scl_o | output | 1 | SCL output value, always 0 |
| sda_oe | output | 1 | SDA output enable |
| sda_o | output | 1 | SDA output value while enabled |

## Verification
Let acceptance be the clock edge at which the strobe is taken. Quarter k of bit b then occupies the cycles from (4b+k)×`cmd_dly` to (4b+k+1)×`cmd_dly`−1 after acceptance. `ready` must still be low in the last cycle of the command and high in the cycle after it: at 4×`cmd_dly` for START and STOP, and at 36×`cmd_dly` for a shift. The bench keeps a cycle counter from acceptance and samples the line outputs on the falling clock edge in the middle of every quarter. Bus status and `rx_data` are read on the falling edge that ends the command. Each SDA input bit is applied at the start of its bit period, several cycles before the sampling edge, so the input synchroniser has time to settle.

// File: rtl/i2c_eng_pkg.sv
// Package: shared command and SDA drive encodings for the I2C bit engine.
// Assumes: command codes match the cmd_kind port encoding of the top module.
package i2c_eng_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_START = 2'd1,
        CMD_STOP  = 2'd2,
        CMD_SHIFT = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        SDA_REL  = 2'd0,
        SDA_LOW  = 2'd1,
        SDA_HIGH = 2'd2
    } sda_e;

endpackage

// File: rtl/i2c_qtr_timer.sv
// Module: quarter-period timer. It latches the delay on load and then pulses
// tick once every DLY cycles while run is high.
// Assumes: load happens only while run is low, and the delay is greater than 2.
module i2c_qtr_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] dly_in,
    input  logic             run,
    output logic             tick
);

    logic [DLY_W-1:0] dly_r;
    logic [DLY_W-1:0] cnt_r;

    // Latch the quarter length and count down one quarter at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_r <= '0;
            cnt_r <= '0;
        end else if (load) begin
            dly_r <= dly_in;
            cnt_r <= dly_in - 1'b1;
        end else if (run) begin
            if (cnt_r == '0) cnt_r <= dly_r - 1'b1;
            else             cnt_r <= cnt_r - 1'b1;
        end
    end

    assign tick = run && (cnt_r == '0);

    // A quarter never lasts a single cycle.
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // The delay given with a command must exceed 2.
    assert_dly_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (dly_in > DLY_W'(2)));

endmodule

// File: rtl/i2c_bit_shifter.sv
// Module: transmit and receive shift registers for one frame, plus the
// SDA input synchroniser.
// Assumes: advance pulses at the end of each bit; sample pulses at the end of
// the third quarter of each bit.
module i2c_bit_shifter #(
    parameter int FRAME_BITS  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] tx_in,
    input  logic                  advance,
    input  logic                  sample,
    input  logic                  sda_in,
    output logic                  cur_bit,
    output logic                  last_bit,
    output logic [FRAME_BITS-1:0] rx_out
);

    localparam int IDX_W = $clog2(FRAME_BITS + 1);

    logic                  sda_s;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [FRAME_BITS-1:0] rx_sr;
    logic [IDX_W-1:0]      idx_r;

    generate
        if (SYNC_STAGES > 1) begin : g_sync_chain
            logic [SYNC_STAGES-1:0] chain_r;
            // Bring the asynchronous pad level into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_r <= '1;
                else        chain_r <= {chain_r[SYNC_STAGES-2:0], sda_in};
            end
            assign sda_s = chain_r[SYNC_STAGES-1];
        end else begin : g_sync_single
            logic flop_r;
            // Single-flop capture when only one stage is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) flop_r <= 1'b1;
                else        flop_r <= sda_in;
            end
            assign sda_s = flop_r;
        end
    endgenerate

    // Load the outgoing frame and move to the next bit, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            idx_r <= '0;
        end else if (load) begin
            tx_sr <= tx_in;
            idx_r <= '0;
        end else if (advance) begin
            tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
            idx_r <= idx_r + 1'b1;
        end
    end

    // Collect the sampled SDA levels; the first bit ends up in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_sr <= '0;
        else if (sample) rx_sr <= {rx_sr[FRAME_BITS-2:0], sda_s};
    end

    assign cur_bit  = tx_sr[FRAME_BITS-1];
    assign last_bit = (idx_r == IDX_W'(FRAME_BITS - 1));
    assign rx_out   = rx_sr;

    // The bit index never runs past the end of a frame.
    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_r <= IDX_W'(FRAME_BITS));

endmodule

// File: rtl/i2c_line_drive.sv
// Module: decodes the engine state into the SCL pull-down and the SDA drive
// mode for the current quarter.
// Assumes: all inputs come from registers. The held SDA mode is the value
// driven in the previous cycle.
module i2c_line_drive
    import i2c_eng_pkg::*;
(
    input  logic       busy,
    input  logic       bus_open,
    input  cmd_e       op,
    input  logic       restart,
    input  logic [1:0] qtr,
    input  logic       cur_bit,
    input  sda_e       hold,
    input  logic       active_en,
    input  logic       early_en,
    output logic       scl_low,
    output sda_e       mode
);

    sda_e hold_soft;
    sda_e pull_up;

    assign hold_soft = (hold == SDA_HIGH) ? SDA_REL : hold;
    assign pull_up   = active_en ? SDA_HIGH : SDA_REL;

    // Choose the line levels for each command and quarter.
    always_comb begin
        scl_low = 1'b0;
        mode    = SDA_REL;
        if (!busy) begin
            scl_low = bus_open;
            mode    = hold_soft;
        end else begin
            case (op)
                CMD_START: begin
                    if (restart) begin
                        case (qtr)
                            2'd0:    begin scl_low = 1'b1; mode = pull_up; end
                            2'd1:    mode = SDA_REL;
                            default: mode = SDA_LOW;
                        endcase
                    end else begin
                        mode = qtr[1] ? SDA_LOW : SDA_REL;
                    end
                end
                CMD_STOP: begin
                    case (qtr)
                        2'd0:    begin scl_low = 1'b1; mode = SDA_LOW; end
                        2'd3:    mode = pull_up;
                        default: mode = SDA_LOW;
                    endcase
                end
                CMD_SHIFT: begin
                    case (qtr)
                        2'd0: begin
                            scl_low = 1'b1;
                            mode    = (early_en && hold == SDA_LOW && cur_bit)
                                      ? SDA_REL : hold_soft;
                        end
                        2'd1: begin
                            scl_low = 1'b1;
                            mode    = cur_bit ? pull_up : SDA_LOW;
                        end
                        default: mode = cur_bit ? SDA_REL : SDA_LOW;
                    endcase
                end
                default: begin
                    scl_low = bus_open;
                    mode    = hold_soft;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_bit_engine.sv
// Module: I2C bit-level master engine (top). It accepts START, STOP and
// nine-bit shift commands and sequences them through four quarters per bit.
// Assumes: the sequencer waits for ready; cmd_dly is greater than 2; SCL is
// never stretched by a target.
module i2c_bit_engine #(
    parameter int DLY_W       = 8,
    parameter int FRAME_BITS  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active_sda_en,
    input  logic                  early_rel_en,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_kind,
    input  logic [DLY_W-1:0]      cmd_dly,
    input  logic [FRAME_BITS-1:0] tx_data,
    input  logic                  sda_i,
    output logic                  ready,
    output logic                  bus_open,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  scl_oe,
    output logic                  scl_o,
    output logic                  sda_oe,
    output logic                  sda_o
);

    import i2c_eng_pkg::*;

    cmd_e       kind_in;
    cmd_e       op_r;
    logic       busy_r;
    logic       restart_r;
    logic [1:0] qtr_r;
    logic       open_r;
    sda_e       hold_r;
    sda_e       mode_now;
    logic       scl_low_now;
    logic       tick;
    logic       cur_bit;
    logic       last_bit;
    logic       accept;
    logic       qtr_end;
    logic       done;

    assign kind_in = cmd_e'(cmd_kind);
    assign accept  = cmd_valid && !busy_r && (kind_in != CMD_NONE);
    assign qtr_end = tick && (qtr_r == 2'd3);
    assign done    = qtr_end && ((op_r != CMD_SHIFT) || last_bit);

    i2c_qtr_timer #(.DLY_W(DLY_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .dly_in (cmd_dly),
        .run    (busy_r),
        .tick   (tick)
    );

    i2c_bit_shifter #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && kind_in == CMD_SHIFT),
        .tx_in    (tx_data),
        .advance  (qtr_end && op_r == CMD_SHIFT),
        .sample   (tick && qtr_r == 2'd2 && op_r == CMD_SHIFT),
        .sda_in   (sda_i),
        .cur_bit  (cur_bit),
        .last_bit (last_bit),
        .rx_out   (rx_data)
    );

    i2c_line_drive u_drive (
        .busy      (busy_r),
        .bus_open  (open_r),
        .op        (op_r),
        .restart   (restart_r),
        .qtr       (qtr_r),
        .cur_bit   (cur_bit),
        .hold      (hold_r),
        .active_en (active_sda_en),
        .early_en  (early_rel_en),
        .scl_low   (scl_low_now),
        .mode      (mode_now)
    );

    // Take a command when idle and hold it until its last quarter ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_r    <= 1'b0;
            op_r      <= CMD_NONE;
            restart_r <= 1'b0;
        end else if (accept) begin
            busy_r    <= 1'b1;
            op_r      <= kind_in;
            restart_r <= open_r;
        end else if (done) begin
            busy_r    <= 1'b0;
        end
    end

    // Step through the four quarters of each bit or condition.
    always_ff @(posedge clk) begin
        if (!rst_n)      qtr_r <= 2'd0;
        else if (accept) qtr_r <= 2'd0;
        else if (tick)   qtr_r <= qtr_r + 2'd1;
    end

    // Track whether the bus sits between a START and a STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)                        open_r <= 1'b0;
        else if (done && op_r == CMD_START) open_r <= 1'b1;
        else if (done && op_r == CMD_STOP)  open_r <= 1'b0;
    end

    // Remember the last SDA drive so the next bit can hold or release it.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_r <= SDA_REL;
        else if (busy_r) hold_r <= mode_now;
    end

    assign ready    = !busy_r;
    assign bus_open = open_r;
    assign scl_oe   = scl_low_now;
    assign scl_o    = 1'b0;
    assign sda_oe   = (mode_now != SDA_REL);
    assign sda_o    = (mode_now == SDA_HIGH);

    // An accepted strobe makes the engine busy on the next cycle.
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ready && cmd_kind != 2'd0) |=> !ready);

    // SDA is never driven high unless active drive is enabled.
    assert_passive_sda_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active_sda_en |-> !(sda_oe && sda_o));

    // Opening the bus leaves SCL and SDA both held low.
    assert_open_levels_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_open) |-> (scl_oe && sda_oe && !sda_o));

    // Closing the bus leaves SCL released and SDA not driven low.
    assert_close_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_open) |-> (!scl_oe && !(sda_oe && !sda_o)));

endmodule

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       act_en;
    logic       early_en;
    logic       cmd_valid;
    logic [1:0] cmd_kind;
    logic [7:0] cmd_dly;
    logic [8:0] tx_data;
    logic       sda_i;
    logic       ready;
    logic       bus_open;
    logic [8:0] rx_data;
    logic       scl_oe;
    logic       scl_o;
    logic       sda_oe;
    logic       sda_o;

    int checks   = 0;
    int errors   = 0;
    bit finished = 1'b0;

    logic [1:0] md [0:35];
    logic       sc [0:35];

    always #5 clk = ~clk;

    i2c_bit_engine u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .active_sda_en (act_en),
        .early_rel_en  (early_en),
        .cmd_valid     (cmd_valid),
        .cmd_kind      (cmd_kind),
        .cmd_dly       (cmd_dly),
        .tx_data       (tx_data),
        .sda_i         (sda_i),
        .ready         (ready),
        .bus_open      (bus_open),
        .rx_data       (rx_data),
        .scl_oe        (scl_oe),
        .scl_o         (scl_o),
        .sda_oe        (sda_oe),
        .sda_o         (sda_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // SDA mode encoding: 0 released, 1 driven low, 2 driven high.
    function automatic int mode_now();
        return sda_oe ? (sda_o ? 2 : 1) : 0;
    endfunction

    // Issue one command, record the mid-quarter line levels and check its
    // duration (R3). Ends on the falling edge after completion.
    task automatic run_cmd(input logic [1:0] kind, input int dly,
                           input logic [8:0] data, input logic [8:0] rxpat,
                           input bit spur);
        int nq;
        int total;
        nq    = (kind == 2'd3) ? 36 : 4;
        total = nq * dly;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_kind  = kind;
        cmd_dly   = 8'(dly);
        tx_data   = data;
        for (int n = 0; n <= total; n++) begin
            @(negedge clk);
            if (n == 0) cmd_valid = 1'b0;
            if (n < total && (n % (4 * dly)) == 0) sda_i = rxpat[8 - n / (4 * dly)];
            if (spur && n == 2) begin
                cmd_valid = 1'b1;
                cmd_kind  = 2'd1;
                cmd_dly   = 8'd3;
            end
            if (spur && n == 3) cmd_valid = 1'b0;
            if (n < total && (n % dly) == dly / 2) begin
                md[n / dly] = 2'(mode_now());
                sc[n / dly] = scl_oe;
            end
            if (n == total - 1) check("R3 busy in last cycle", int'(ready), 0);
            if (n == total)     check("R3 ready after command", int'(ready), 1);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; act_en = 1'b0; early_en = 1'b0; cmd_valid = 1'b0;
        cmd_kind = 2'd0; cmd_dly = 8'd4; tx_data = '0; sda_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", int'(ready), 1);
        check("R1 bus_open", int'(bus_open), 0);
        check("R1 scl_oe", int'(scl_oe), 0);
        check("R1 sda_oe", int'(sda_oe), 0);
        cmd_valid = 1'b1; cmd_kind = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 kind 0 ignored", int'(ready), 1);
        @(negedge clk);
        check("R2 kind 0 ignored, bus", int'(bus_open), 0);
    endtask

    task automatic t_start();
        act_en = 1'b0; early_en = 1'b0;
        run_cmd(2'd1, 4, 9'd0, 9'h1ff, 1'b0);
        for (int q = 0; q < 4; q++) begin
            check($sformatf("R4 start scl q%0d", q), int'(sc[q]), 0);
            check($sformatf("R4 start sda q%0d", q), int'(md[q]), (q < 2) ? 0 : 1);
        end
        check("R4 bus_open after start", int'(bus_open), 1);
        check("R4 scl held low", int'(scl_oe), 1);
        check("R4 sda held low", mode_now(), 1);
    endtask

    task automatic t_shift(input string name, input int dly, input logic [8:0] data,
                           input logic [8:0] rxpat, input bit act, input bit early);
        act_en = act; early_en = early;
        run_cmd(2'd3, dly, data, rxpat, 1'b0);
        for (int b = 0; b < 9; b++) begin
            logic cur;
            logic prev_low;
            int   exp0;
            cur      = data[8 - b];
            prev_low = (b == 0) ? 1'b1 : !data[9 - b];
            exp0     = (early && prev_low && cur) ? 0 : (prev_low ? 1 : 0);
            check($sformatf("R7 %s bit%0d scl q0", name, b), int'(sc[4*b]), 1);
            check($sformatf("R10 %s bit%0d sda q0", name, b), int'(md[4*b]), exp0);
            check($sformatf("R9 %s bit%0d sda q1", name, b), int'(md[4*b+1]),
                  cur ? (act ? 2 : 0) : 1);
            check($sformatf("R7 %s bit%0d scl q2", name, b), int'(sc[4*b+2]), 0);
            check($sformatf("R7 %s bit%0d sda q2", name, b), int'(md[4*b+2]), cur ? 0 : 1);
        end
        check($sformatf("R8 %s rx_data", name), int'(rx_data), int'(rxpat));
        check($sformatf("R7 %s bus stays open", name), int'(bus_open), 1);
    endtask

    task automatic t_restart();
        act_en = 1'b1; early_en = 1'b0;
        run_cmd(2'd1, 3, 9'd0, 9'h1ff, 1'b0);
        check("R5 restart scl q0", int'(sc[0]), 1);
        check("R9 restart sda q0 high", int'(md[0]), 2);
        for (int q = 1; q < 4; q++) begin
            check($sformatf("R5 restart scl q%0d", q), int'(sc[q]), 0);
            check($sformatf("R5 restart sda q%0d", q), int'(md[q]), (q == 1) ? 0 : 1);
        end
        check("R5 bus still open", int'(bus_open), 1);
    endtask

    task automatic t_stop_with_stray();
        act_en = 1'b1; early_en = 1'b0;
        run_cmd(2'd2, 5, 9'd0, 9'h1ff, 1'b1);
        for (int q = 0; q < 4; q++) begin
            check($sformatf("R6 stop scl q%0d", q), int'(sc[q]), (q == 0) ? 1 : 0);
        end
        check("R6 stop sda q0", int'(md[0]), 1);
        check("R6 stop sda q1", int'(md[1]), 1);
        check("R6 stop sda q2", int'(md[2]), 1);
        check("R9 stop sda q3 high", int'(md[3]), 2);
        check("R6 bus closed", int'(bus_open), 0);
        check("R6 scl released", int'(scl_oe), 0);
        check("R6 sda released", int'(sda_oe), 0);
        repeat (40) @(negedge clk);
        check("R2 stray start ignored, ready", int'(ready), 1);
        check("R2 stray start ignored, bus", int'(bus_open), 0);
    endtask

    initial begin
        t_reset();
        t_start();
        t_shift("plain", 3, 9'b101100101, 9'b011010011, 1'b0, 1'b0);
        t_restart();
        t_shift("fast", 4, 9'b010110011, 9'b110000110, 1'b1, 1'b1);
        t_stop_with_stray();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule